// File: doc/BRIEF.md
# Match-Compare Event Timer

This peripheral keeps a 32-bit up-counter driven by a slow timer clock, oversampled on the bus clock, and compares it against a programmable match value. Each time the count steps onto the match value, the block emits a one-cycle interrupt pulse whose rising edge marks the event. Software sets the match value, starts or stops counting, picks whether the count snaps back to zero after a match, and selects an optional divide-by-four prescaler on the timer clock.

Zeroing the count is a request that crosses into the timer domain. It takes effect only on the next rising edge of the timer clock. A status flag stays set from the bus write until the timer side has acknowledged the clear, so a driver can poll that flag before it re-arms the timer. Register accesses are single-cycle word transfers. Read data is combinational on the address.

Top module: `evt_match_timer`

## Requirements
- R1: After reset every register reads zero, the count is zero, the interrupt is low and the clear-pending flag is clear.
- R2: With enable bit 0 (register 0x08) set and divide-by-1 selected, the count at 0x04 rises by exactly one per rising edge of the timer clock.
- R3: Clearing enable bit 0 freezes the count at its present value, and timer-clock edges then leave it unchanged.
- R4: Clock-control value 0x3 (register 0x10, bits 1:0) makes the count advance once per four timer-clock edges. Every other value gives one advance per edge.
- R5: When an advance makes the count equal to the match value (register 0x00), the interrupt output is high for exactly one bus-clock cycle.
- R6: With enable bit 1 set, the advance after the count equals the match value returns the count to zero. With bit 1 clear, the count runs on past the match value.
- R7: A write of any value to 0x0C zeroes the count and the prescaler on the next timer-clock edge. Bit 10 of the status register at 0x14 is 1 from the cycle after the write until the acknowledge has returned, then 0.
- R8: Match reads back all 32 bits. Enable and clock control keep only bits 1:0. All other bits, the clear register and unmapped offsets read zero.
- R9: While enable bit 0 is clear, no interrupt is produced even if the count equals the match value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also used to oversample the timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrClkIn | input | 1 | Slow timer clock, asynchronous to clk |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irq | output | 1 | Match interrupt pulse |

## Verification
The counting core is exercised with six stimulus patterns. Each one mixes a prescaler selection, a clear-on-match setting and a match value against a known number of timer-clock edges, and the bench compares the final count and the number of interrupt pulses. A match of zero with auto-clear distinguishes a design that fires on every advance from one that fires only once. A non-0x3 divider code separates a decode of both bits from a decode of bit 1 alone. Running both dividers with auto-clear shows whether the wrap happens one advance after the match or on the match itself. Directed tests then cover the pending flag before and after the crossing, the frozen count while disabled, the silence of a disabled match, and the read-back masking.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  // Register byte offsets. Decoded by the register file.
  localparam logic [7:0] OFS_MATCH  = 8'h00;
  localparam logic [7:0] OFS_COUNT  = 8'h04;
  localparam logic [7:0] OFS_ENABLE = 8'h08;
  localparam logic [7:0] OFS_CLEAR  = 8'h0C;
  localparam logic [7:0] OFS_CLKCTL = 8'h10;
  localparam logic [7:0] OFS_STATUS = 8'h14;

  // Clock-control code that selects the divide-by-four prescaler.
  localparam logic [1:0] CLK_DIV4_CODE = 2'd3;

  // Position of the clear-pending flag in the status register.
  localparam int STS_PEND_BIT = 10;

  // Strobes handed from the register file to the counting datapath.
  typedef struct packed {
    logic enable;      // counting allowed
    logic clrOnMatch;  // return to zero after the match value
    logic div4;        // prescale timer clock by four
    logic clrToggle;   // flips once per clear request
  } tmr_ctrl_t;

endpackage

// File: rtl/evt_timer_tick_sync.sv
// Brings the asynchronous timer clock into clk and marks each rising edge
// with a single-cycle tick.
module evt_timer_tick_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tmrClkIn,
  output logic tick
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] syncQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ[0] <= 1'b0;
    else       syncQ[0] <= tmrClkIn;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[i] <= 1'b0;
      else       syncQ[i] <= syncQ[i-1];
    end
  end

  assign tick = syncQ[LAST-1] & ~syncQ[LAST];
endmodule

// File: rtl/evt_timer_core.sv
// Timer-domain datapath: prescaler, counter, match compare, clear acknowledge.
module evt_timer_core
  import evt_timer_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrClkIn,
  input  tmr_ctrl_t         ctrlS,
  input  logic [DATA_W-1:0] matchVal,
  output logic [DATA_W-1:0] count,
  output logic              clrAck,
  output logic              irqPulse
);
  localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};

  logic              tick;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preLimit;
  logic              clrNow;
  logic              preWrap;
  logic              advance;
  logic [DATA_W-1:0] nextCount;

  evt_timer_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk      (clk),
    .rstN     (rstN),
    .tmrClkIn (tmrClkIn),
    .tick     (tick)
  );

  always_comb begin
    preLimit  = ctrlS.div4 ? PRE_MAX : '0;
    clrNow    = tick && (ctrlS.clrToggle != clrAck);
    preWrap   = (preCnt >= preLimit);
    advance   = tick && ctrlS.enable && preWrap && !clrNow;
    if (ctrlS.clrOnMatch && (count == matchVal)) nextCount = '0;
    else                                         nextCount = count + DATA_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt   <= '0;
      count    <= '0;
      clrAck   <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= advance && (nextCount == matchVal);
      if (clrNow) begin
        preCnt <= '0;
        count  <= '0;
        clrAck <= ctrlS.clrToggle;
      end else if (tick && ctrlS.enable) begin
        preCnt <= preWrap ? '0 : preCnt + PRE_W'(1);
        if (advance) count <= nextCount;
      end
    end
  end
endmodule

// File: rtl/evt_timer_regs.sv
// Bus-side register file, clear request toggle and acknowledge synchroniser.
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [DATA_W-1:0] count,
  input  logic              clrAck,
  output tmr_ctrl_t         ctrlS,
  output logic [DATA_W-1:0] matchVal,
  output logic              clrPending
);
  localparam logic [ADDR_W-1:0] A_MATCH  = ADDR_W'(OFS_MATCH);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFS_COUNT);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFS_CLEAR);
  localparam logic [ADDR_W-1:0] A_CLKCTL = ADDR_W'(OFS_CLKCTL);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam int LAST = SYNC_STAGES - 1;

  logic [1:0]    enableReg;
  logic [1:0]    clkCtlReg;
  logic          clrReq;
  logic [LAST:0] ackSync;
  logic          wrEn;

  assign wrEn = busSel && busWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchVal  <= '0;
      enableReg <= '0;
      clkCtlReg <= '0;
      clrReq    <= 1'b0;
    end else if (wrEn) begin
      case (busAddr)
        A_MATCH:  matchVal  <= busWdata;
        A_ENABLE: enableReg <= busWdata[1:0];
        A_CLKCTL: clkCtlReg <= busWdata[1:0];
        // A request already in flight will zero the count anyway.
        A_CLEAR:  if (!clrPending) clrReq <= ~clrReq;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ackSync[0] <= 1'b0;
    else       ackSync[0] <= clrAck;
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_ack
    always_ff @(posedge clk) begin
      if (!rstN) ackSync[i] <= 1'b0;
      else       ackSync[i] <= ackSync[i-1];
    end
  end

  assign clrPending = clrReq ^ ackSync[LAST];

  always_comb begin
    ctrlS.enable     = enableReg[0];
    ctrlS.clrOnMatch = enableReg[1];
    ctrlS.div4       = (clkCtlReg == CLK_DIV4_CODE);
    ctrlS.clrToggle  = clrReq;
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_MATCH:  busRdata = matchVal;
      A_COUNT:  busRdata = count;
      A_ENABLE: busRdata[1:0] = enableReg;
      A_CLKCTL: busRdata[1:0] = clkCtlReg;
      A_STATUS: busRdata[STS_PEND_BIT] = clrPending;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_match_timer.sv
module evt_match_timer
  import evt_timer_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrClkIn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);
  tmr_ctrl_t         ctrlS;
  logic [DATA_W-1:0] matchVal;
  logic [DATA_W-1:0] tmrCount;
  logic              clrAck;
  logic              clrPending;

  evt_timer_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) regs_i (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .count      (tmrCount),
    .clrAck     (clrAck),
    .ctrlS      (ctrlS),
    .matchVal   (matchVal),
    .clrPending (clrPending)
  );

  evt_timer_core #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) core_i (
    .clk      (clk),
    .rstN     (rstN),
    .tmrClkIn (tmrClkIn),
    .ctrlS    (ctrlS),
    .matchVal (matchVal),
    .count    (tmrCount),
    .clrAck   (clrAck),
    .irqPulse (irq)
  );
endmodule

// File: rtl/evt_match_timer_chk.sv
module evt_match_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic              irq,
  input logic              tmrEn,
  input logic              clrPending,
  input logic [DATA_W-1:0] count
);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(OFS_CLEAR);

  assert_irq_one_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(tmrEn));

  assert_count_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!tmrEn && !clrPending) |=> $stable(count));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> (count == $past(count) + DATA_W'(1) || count == '0));

  assert_pending_from_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clrPending) |-> $past(busSel && busWr && busAddr == A_CLEAR));
endmodule

bind evt_match_timer evt_match_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .irq        (irq),
  .tmrEn      (ctrlS.enable),
  .clrPending (clrPending),
  .count      (tmrCount)
);

// File: tb/evt_match_timer_tb_top.sv
`timescale 1ns/1ps
module evt_match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tmrClkIn = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;

  int testsRun = 0;
  int testsFailed = 0;
  int irqSeen = 0;

  always #2 clk = ~clk;  // 250 MHz

  evt_match_timer dut_i (
    .clk(clk), .rstN(rstN), .tmrClkIn(tmrClkIn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  always @(posedge clk) if (rstN && irq) irqSeen <= irqSeen + 1;

  typedef struct packed {
    logic [1:0]  divSel;
    logic        autoClr;
    logic [31:0] matchV;
    logic [7:0]  edges;
    logic [31:0] expCount;
    logic [7:0]  expIrq;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 32'd5,   8'd8,  32'd8, 8'd1},
    '{2'd3, 1'b0, 32'd2,   8'd10, 32'd2, 8'd1},
    '{2'd2, 1'b1, 32'd3,   8'd9,  32'd1, 8'd2},
    '{2'd0, 1'b1, 32'd0,   8'd3,  32'd0, 8'd3},
    '{2'd3, 1'b1, 32'd1,   8'd12, 32'd1, 8'd2},
    '{2'd1, 1'b0, 32'd100, 8'd6,  32'd6, 8'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic timerEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tmrClkIn = 1'b1;
      repeat (3) @(negedge clk);
      tmrClkIn = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic zeroCount();
    busWrite(8'h08, 32'h0);
    busWrite(8'h0C, 32'h1234);
    timerEdges(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int irqBase;
    repeat (5) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 6; a++) begin
      busRead(8'(a * 4), rd);
      check("R1 reg", rd, 32'd0);
    end

    // Vector table: R2 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      zeroCount();
      busWrite(8'h10, {30'd0, VECS[v].divSel});
      busWrite(8'h00, VECS[v].matchV);
      irqBase = irqSeen;
      busWrite(8'h08, {30'd0, VECS[v].autoClr, 1'b1});
      timerEdges(int'(VECS[v].edges));
      busWrite(8'h08, 32'h0);
      busRead(8'h04, rd);
      check($sformatf("R2/R4/R6 count vec%0d", v), rd, VECS[v].expCount);
      check($sformatf("R5 irq pulses vec%0d", v), 32'(irqSeen - irqBase), 32'(VECS[v].expIrq));
    end

    // R3: disabling freezes the count
    zeroCount();
    busWrite(8'h10, 32'h0);
    busWrite(8'h00, 32'hFFFF_0000);
    busWrite(8'h08, 32'h1);
    timerEdges(3);
    busRead(8'h04, rd);
    check("R2 count after 3 edges", rd, 32'd3);
    busWrite(8'h08, 32'h0);
    timerEdges(4);
    busRead(8'h04, rd);
    check("R3 frozen count", rd, 32'd3);

    // R9: no interrupt while disabled, then R5 once enabled
    busWrite(8'h00, 32'd3);
    irqBase = irqSeen;
    timerEdges(2);
    check("R9 no irq while disabled", 32'(irqSeen - irqBase), 32'd0);
    busWrite(8'h00, 32'd4);
    busWrite(8'h08, 32'h1);
    timerEdges(1);
    busWrite(8'h08, 32'h0);
    check("R5 irq on enabled match", 32'(irqSeen - irqBase), 32'd1);

    // R7: clear crossing and pending flag
    busWrite(8'h0C, 32'h0);
    busRead(8'h14, rd);
    check("R7 pending set", rd, 32'h0000_0400);
    busRead(8'h04, rd);
    check("R7 count held until edge", rd, 32'd4);
    timerEdges(1);
    busRead(8'h14, rd);
    check("R7 pending dropped", rd, 32'h0);
    busRead(8'h04, rd);
    check("R7 count zeroed", rd, 32'd0);

    // R8: read-back masking
    busWrite(8'h00, 32'hDEAD_BEEF);
    busRead(8'h00, rd);
    check("R8 match readback", rd, 32'hDEAD_BEEF);
    busWrite(8'h08, 32'hFFFF_FFFC);
    busRead(8'h08, rd);
    check("R8 enable masked", rd, 32'h0);
    busWrite(8'h10, 32'hFFFF_FFF5);
    busRead(8'h10, rd);
    check("R8 clkctl masked", rd, 32'h1);
    busRead(8'h0C, rd);
    check("R8 clear reads zero", rd, 32'h0);
    busRead(8'h20, rd);
    check("R8 unmapped reads zero", rd, 32'h0);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule